// File: doc/BRIEF.md
# Virtualized Time Counter CSR Unit

This block answers register reads and writes for the time counter as software sees it, and holds the guest time offset. Each cycle it can accept one request that names one of four selectors: the low or high part of the counter view, or the low or high part of the offset. The counter view is built from an external 64-bit free-running timer. While the hart runs in virtualized mode, the 64-bit offset is added to the timer. Otherwise the timer value is returned as it is.

The datapath width `XLEN` is 32 or 64. With a 32-bit datapath, both the counter view and the offset are reached as two halves, and each half of the offset is written on its own. With a 64-bit datapath, the low selectors reach the full 64-bit value and the high selectors do not exist. When no timer source is present, every request is refused. The response appears one clock after the request, and it carries the read data and an illegal-access flag. A request that writes returns the value the register held before the write.

Top module: `vtime_csr_unit`

## Requirements
- R1: After reset, `rsp_valid` is 0 and the offset is zero, so reading either half of the offset returns 0.
- R2: A counter-low read (`req_sel`=0) with `virt_mode`=1 returns the low XLEN bits of timer + offset. The response comes one clock after the request and is based on the timer value in the request cycle.
- R3: A counter-low read with `virt_mode`=0 returns the low XLEN bits of the bare timer, whatever the offset holds.
- R4: With XLEN=32, a counter-high read (`req_sel`=1) returns bits 63:32 of the same optionally-offset 64-bit sum, including any carry out of the low half.
- R5: An offset-low access (`req_sel`=2) with XLEN=32 writes only offset bits 31:0 and reads bits 31:0. With XLEN=64 it writes and reads all 64 bits.
- R6: With XLEN=32, an offset-high access (`req_sel`=3) writes only offset bits 63:32, keeps the low half, and reads bits 63:32.
- R7: An offset write takes effect on the clock edge that accepts it. The writing request returns the old value, and a request in the next cycle sees the new value. Writes (`req_wr`=1) to the counter selectors change nothing.
- R8: When `timer_present`=0, every request gets `rsp_illegal`=1 and `rsp_rdata`=0, and no write takes effect.
- R9: The addition of timer and offset wraps modulo 2^64.
- R10: With XLEN=64, the high selectors (`req_sel`=1 or 3) get `rsp_illegal`=1 and `rsp_rdata`=0, and a write to them has no effect.
- R11: `rsp_valid` is 1 in exactly the cycle after each cycle with `req_valid`=1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_sel | input | 2 | 0 counter low, 1 counter high, 2 offset low, 3 offset high |
| req_wr | input | 1 | Request writes `req_wdata` |
| req_wdata | input | XLEN | Write data |
| virt_mode | input | 1 | Hart runs virtualized; the offset is applied |
| timer_present | input | 1 | An external timer source exists |
| timer_val | input | 64 | Current external timer value |
| rsp_valid | output | 1 | Response is valid |
| rsp_rdata | output | XLEN | Read data (old value on a write) |
| rsp_illegal | output | 1 | Request refused as an illegal access |

## Verification
Two things can fall in the same cycle: an offset write and the read of the old offset value by that same request. A back-to-back write is followed at once by a counter read that depends on the new offset. The bench makes this happen with directed sequences and with random requests that mix writes and reads in consecutive cycles. A reference model updates its offset only after it has judged the response. So the writing request must return the pre-write value, and the very next request must reflect the new value.

// File: rtl/tcsr_pkg.sv
package tcsr_pkg;
   localparam int TMR_W  = 64;
   localparam int HALF_W = 32;

   typedef enum logic [1:0] {
      SEL_CNT_LO = 2'd0,
      SEL_CNT_HI = 2'd1,
      SEL_OFS_LO = 2'd2,
      SEL_OFS_HI = 2'd3
   } tcsr_sel_e;

   typedef struct packed {
      logic legal;
      logic rd_cnt;
      logic rd_hi;
      logic wr_lo;
      logic wr_hi;
   } tcsr_dec_t;
endpackage

// File: rtl/tcsr_decode.sv
module tcsr_decode
   import tcsr_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic       req_valid,
   input  logic [1:0] req_sel,
   input  logic       req_wr,
   input  logic       timer_present,
   output tcsr_dec_t  dec
);
   logic sel_exists;
   logic is_ofs;
   logic is_hi;

   assign is_ofs = (req_sel == SEL_OFS_LO) || (req_sel == SEL_OFS_HI);
   assign is_hi  = (req_sel == SEL_CNT_HI) || (req_sel == SEL_OFS_HI);

   generate
      if (XLEN == 64) begin : g_wide
         assign sel_exists = !is_hi;
      end else begin : g_narrow
         assign sel_exists = 1'b1;
      end
   endgenerate

   always_comb begin
      dec.legal  = req_valid && timer_present && sel_exists;
      dec.rd_cnt = !is_ofs;
      dec.rd_hi  = is_hi;
      dec.wr_lo  = dec.legal && req_wr && (req_sel == SEL_OFS_LO);
      dec.wr_hi  = dec.legal && req_wr && (req_sel == SEL_OFS_HI);
   end
endmodule

// File: rtl/tcsr_offset_reg.sv
module tcsr_offset_reg
   import tcsr_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [XLEN-1:0]  wdata,
   output logic [TMR_W-1:0] ofs_q
);
   generate
      if (XLEN == TMR_W) begin : g_full
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     ofs_q <= '0;
            else if (wr_lo) ofs_q <= wdata;
         end
      end else begin : g_halves
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ofs_q <= '0;
            end else begin
               if (wr_lo) ofs_q[HALF_W-1:0]     <= wdata[HALF_W-1:0];
               if (wr_hi) ofs_q[TMR_W-1:HALF_W] <= wdata[HALF_W-1:0];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/tcsr_time_sum.sv
module tcsr_time_sum
   import tcsr_pkg::*;
(
   input  logic [TMR_W-1:0] timer_val,
   input  logic [TMR_W-1:0] ofs,
   input  logic             virt_mode,
   output logic [TMR_W-1:0] view
);
   logic [TMR_W-1:0] addend;
   assign addend = virt_mode ? ofs : '0;
   assign view   = timer_val + addend;
endmodule

// File: rtl/tcsr_rsp.sv
module tcsr_rsp
   import tcsr_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  tcsr_dec_t        dec,
   input  logic [TMR_W-1:0] view,
   input  logic [TMR_W-1:0] ofs,
   output logic             rsp_valid,
   output logic [XLEN-1:0]  rsp_rdata,
   output logic             rsp_illegal
);
   logic [TMR_W-1:0] src;
   logic [TMR_W-1:0] hi_ext;
   logic [XLEN-1:0]  data_nxt;

   assign src    = dec.rd_cnt ? view : ofs;
   assign hi_ext = {{HALF_W{1'b0}}, src[TMR_W-1:HALF_W]};

   always_comb begin
      if (!dec.legal)     data_nxt = '0;
      else if (dec.rd_hi) data_nxt = hi_ext[XLEN-1:0];
      else                data_nxt = src[XLEN-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_rdata   <= '0;
         rsp_illegal <= 1'b0;
      end else begin
         rsp_valid   <= req_valid;
         rsp_rdata   <= req_valid ? data_nxt : '0;
         rsp_illegal <= req_valid && !dec.legal;
      end
   end
endmodule

// File: rtl/vtime_csr_unit.sv
module vtime_csr_unit
   import tcsr_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [1:0]      req_sel,
   input  logic            req_wr,
   input  logic [XLEN-1:0] req_wdata,
   input  logic            virt_mode,
   input  logic            timer_present,
   input  logic [63:0]     timer_val,
   output logic            rsp_valid,
   output logic [XLEN-1:0] rsp_rdata,
   output logic            rsp_illegal
);
   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("vtime_csr_unit: XLEN must be 32 or 64");
      end
   endgenerate

   tcsr_dec_t        dec;
   logic [TMR_W-1:0] ofs_q;
   logic [TMR_W-1:0] view;

   tcsr_decode #(.XLEN(XLEN)) u_dec (
      .req_valid     (req_valid),
      .req_sel       (req_sel),
      .req_wr        (req_wr),
      .timer_present (timer_present),
      .dec           (dec)
   );

   tcsr_offset_reg #(.XLEN(XLEN)) u_ofs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_lo (dec.wr_lo),
      .wr_hi (dec.wr_hi),
      .wdata (req_wdata),
      .ofs_q (ofs_q)
   );

   tcsr_time_sum u_sum (
      .timer_val (timer_val),
      .ofs       (ofs_q),
      .virt_mode (virt_mode),
      .view      (view)
   );

   tcsr_rsp #(.XLEN(XLEN)) u_rsp (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .dec         (dec),
      .view        (view),
      .ofs         (ofs_q),
      .rsp_valid   (rsp_valid),
      .rsp_rdata   (rsp_rdata),
      .rsp_illegal (rsp_illegal)
   );
endmodule

// File: rtl/vtime_csr_unit_chk.sv
module vtime_csr_unit_chk #(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic [1:0]      req_sel,
   input logic            req_wr,
   input logic            virt_mode,
   input logic            timer_present,
   input logic [63:0]     timer_val,
   input logic            rsp_valid,
   input logic [XLEN-1:0] rsp_rdata,
   input logic            rsp_illegal,
   input logic [63:0]     ofs_q
);
   AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R11
   AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R11
   AST_NO_TIMER_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !timer_present) |=> rsp_illegal); // R8
   AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_illegal) |-> (rsp_rdata == '0)); // R8
   AST_NO_TIMER_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !timer_present) |=> $stable(ofs_q)); // R8
   AST_OFS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_wr) |=> $stable(ofs_q)); // R7
   AST_BARE_TIME: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && timer_present && !virt_mode && req_sel == 2'd0)
      |=> (rsp_rdata == $past(timer_val[XLEN-1:0]))); // R3

   generate
      if (XLEN == 64) begin : g_wide_chk
         AST_HI_SEL_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_sel[0]) |=> rsp_illegal); // R10
      end
   endgenerate
endmodule

bind vtime_csr_unit vtime_csr_unit_chk #(.XLEN(XLEN)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_sel       (req_sel),
   .req_wr        (req_wr),
   .virt_mode     (virt_mode),
   .timer_present (timer_present),
   .timer_val     (timer_val),
   .rsp_valid     (rsp_valid),
   .rsp_rdata     (rsp_rdata),
   .rsp_illegal   (rsp_illegal),
   .ofs_q         (ofs_q)
);

// File: tb/vtime_csr_unit_tb_top.sv
module vtime_csr_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_sel = 2'd0;
   logic        req_wr = 1'b0;
   logic [63:0] req_wdata = '0;
   logic        virt_mode = 1'b0;
   logic        timer_present = 1'b1;
   logic [63:0] timer_val = '0;

   logic        rv32, ri32, rv64, ri64;
   logic [31:0] rd32;
   logic [63:0] rd64;

   int errors = 0;
   int checks = 0;
   logic [63:0] ofs32_m = '0;
   logic [63:0] ofs64_m = '0;

   always #10 clk = ~clk;

   vtime_csr_unit #(.XLEN(32)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
      .req_wr(req_wr), .req_wdata(req_wdata[31:0]), .virt_mode(virt_mode),
      .timer_present(timer_present), .timer_val(timer_val),
      .rsp_valid(rv32), .rsp_rdata(rd32), .rsp_illegal(ri32));

   vtime_csr_unit #(.XLEN(64)) dut64_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
      .req_wr(req_wr), .req_wdata(req_wdata), .virt_mode(virt_mode),
      .timer_present(timer_present), .timer_val(timer_val),
      .rsp_valid(rv64), .rsp_rdata(rd64), .rsp_illegal(ri64));

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] view_f(input logic v, input logic [63:0] t, input logic [63:0] o);
      return v ? t + o : t;
   endfunction

   function automatic logic [63:0] exp32(input logic [1:0] s, input logic v, input logic p,
                                         input logic [63:0] t, input logic [63:0] o);
      logic [63:0] vw;
      vw = view_f(v, t, o);
      if (!p) return 64'd0;
      case (s)
         2'd0: return {32'd0, vw[31:0]};
         2'd1: return {32'd0, vw[63:32]};
         2'd2: return {32'd0, o[31:0]};
         default: return {32'd0, o[63:32]};
      endcase
   endfunction

   function automatic logic [63:0] exp64(input logic [1:0] s, input logic v, input logic p,
                                         input logic [63:0] t, input logic [63:0] o);
      if (!p || s[0]) return 64'd0;
      return (s == 2'd0) ? view_f(v, t, o) : o;
   endfunction

   // one request, response checked one clock later, model updated afterwards
   task automatic do_req(input string tag, input logic [1:0] s, input logic w,
                         input logic [63:0] wd, input logic v, input logic p,
                         input logic [63:0] t);
      logic [63:0] e32, e64;
      req_valid = 1'b1; req_sel = s; req_wr = w; req_wdata = wd;
      virt_mode = v; timer_present = p; timer_val = t;
      e32 = exp32(s, v, p, t, ofs32_m);
      e64 = exp64(s, v, p, t, ofs64_m);
      @(negedge clk);
      req_valid = 1'b0;
      check({tag, " R11 valid32"}, {63'd0, rv32}, 64'd1);
      check({tag, " R11 valid64"}, {63'd0, rv64}, 64'd1);
      check({tag, " R8 illegal32"}, {63'd0, ri32}, {63'd0, !p});
      check({tag, " R10 illegal64"}, {63'd0, ri64}, {63'd0, !p || s[0]});
      check({tag, " data32"}, {32'd0, rd32}, e32);
      check({tag, " R10 data64"}, rd64, e64);
      if (p && w) begin
         if (s == 2'd2) ofs32_m[31:0]  = wd[31:0];
         if (s == 2'd3) ofs32_m[63:32] = wd[31:0];
         if (s == 2'd2) ofs64_m = wd;
      end
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [63:0] t, w;
      void'($urandom(32'h5eed1234));
      repeat (3) @(negedge clk);
      check("R1 rsp_valid at reset", {63'd0, rv32}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 idle no response", {63'd0, rv32 | rv64}, 64'd0);
      do_req("R1 offset low zero", 2'd2, 1'b0, 0, 1'b1, 1'b1, 64'h1234);
      do_req("R1 offset high zero", 2'd3, 1'b0, 0, 1'b1, 1'b1, 64'h1234);
      // R5 R6: halves written separately
      do_req("R5 write low", 2'd2, 1'b1, 64'hAAAA_BBBB_0000_0001, 1'b1, 1'b1, 64'h0);
      do_req("R6 write high", 2'd3, 1'b1, 64'h0000_0000_0000_0002, 1'b1, 1'b1, 64'h0);
      do_req("R6 read high", 2'd3, 1'b0, 0, 1'b1, 1'b1, 64'h0);
      do_req("R5 read low", 2'd2, 1'b0, 0, 1'b1, 1'b1, 64'h0);
      // R4: carry from low half into high half
      do_req("R4 carry high", 2'd1, 1'b0, 0, 1'b1, 1'b1, 64'h0000_0005_FFFF_FFFF);
      do_req("R2 virt low", 2'd0, 1'b0, 0, 1'b1, 1'b1, 64'h0000_0005_FFFF_FFFF);
      do_req("R3 bare low", 2'd0, 1'b0, 0, 1'b0, 1'b1, 64'h0000_0005_FFFF_FFFF);
      do_req("R3 bare high", 2'd1, 1'b0, 0, 1'b0, 1'b1, 64'h0000_0005_FFFF_FFFF);
      // R9: wrap modulo 2^64
      do_req("R9 set all ones low", 2'd2, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 64'h0);
      do_req("R9 set all ones high", 2'd3, 1'b1, 64'hFFFF_FFFF, 1'b1, 1'b1, 64'h0);
      do_req("R9 wrap low", 2'd0, 1'b0, 0, 1'b1, 1'b1, 64'd5);
      do_req("R9 wrap high", 2'd1, 1'b0, 0, 1'b1, 1'b1, 64'd5);
      // R7: write and dependent read back to back
      do_req("R7 write returns old", 2'd2, 1'b1, 64'h0000_0010_0000_0010, 1'b1, 1'b1, 64'd100);
      do_req("R7 next cycle sees new", 2'd0, 1'b0, 0, 1'b1, 1'b1, 64'd100);
      do_req("R7 counter write ignored", 2'd0, 1'b1, 64'hDEAD, 1'b1, 1'b1, 64'd7);
      do_req("R7 offset after counter write", 2'd2, 1'b0, 0, 1'b1, 1'b1, 64'd7);
      // R8: no timer
      do_req("R8 write refused", 2'd2, 1'b1, 64'h5555_5555_5555_5555, 1'b1, 1'b0, 64'd9);
      do_req("R8 read refused", 2'd0, 1'b0, 0, 1'b1, 1'b0, 64'd9);
      do_req("R8 offset unchanged", 2'd2, 1'b0, 0, 1'b1, 1'b1, 64'd9);
      // R10: high selector writes refused on the wide instance
      do_req("R10 high write", 2'd3, 1'b1, 64'h77, 1'b1, 1'b1, 64'd1);
      do_req("R10 low after high write", 2'd2, 1'b0, 0, 1'b1, 1'b1, 64'd1);
      @(negedge clk);
      check("R11 idle gap", {63'd0, rv32 | rv64}, 64'd0);
      for (int i = 0; i < 400; i++) begin
         t = {$urandom, $urandom};
         w = {$urandom, $urandom};
         if ($urandom % 8 == 0) t[31:0] = 32'hFFFF_FFFF;
         do_req("rand", 2'($urandom % 4), 1'($urandom % 2), w, 1'($urandom % 2),
                ($urandom % 8) != 0, t);
         if ($urandom % 6 == 0) begin
            @(negedge clk);
            check("R11 rand idle", {63'd0, rv32 | rv64}, 64'd0);
         end
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule